// File: doc/BRIEF.md
# Command and Interrupt Status Controller

This block is the control core of a network controller. The host writes a command byte. That byte selects one of four register pages, hands a three-bit remote DMA command to the DMA engine, starts or stops the controller, and raises a transmit request. A small state machine tracks three conditions: running, offline, and a draining phase. The draining phase lets a frame that is already being received or sent finish before the controller goes offline.

The receive, transmit, DMA, ring-buffer and tally-counter logic sit outside this block. They report to it through one-cycle event pulses and two busy levels. Each event sets a sticky status bit, and the host clears that bit by writing a 1 to it. A mask selects which status bits drive the single interrupt line. Status bit 7 is read-only. It is high while the controller is offline, and it is also held high after a ring overwrite until the ring has been drained or the controller is restarted.

Top module: `cmd_irq_ctrl`

## Requirements
- R1: Command byte layout: bit 0 is stop, bit 1 is start, bit 2 is the transmit request, bits 5:3 are the remote DMA command and bits 7:6 are the page number. After a write, the readback returns the written page, DMA command, stop and start bits together with the current transmit request. `page_o` and `rdma_cmd_o` carry the page and DMA fields.
- R2: A stop command (bit 0 = 1) issued while running with `rx_busy` or `tx_busy` high drops `online_o` on the next cycle. The controller becomes offline, and status bit 7 rises, only in the cycle after both busy inputs are low. A stop issued while already offline keeps the controller offline.
- R3: A stop command issued while no frame is in flight makes the controller offline on the next cycle. Stop takes priority over start when both bits are written together.
- R4: A start command (bit 1 = 1, bit 0 = 0) makes the controller online on the next cycle, from any state. It also clears status bit 7 unless an overwrite is pending in the same cycle.
- R5: Status bit 7 is 1 whenever the controller is offline. It is also set by `ring_ovw_ev` and stays set until `ring_drain_ev` or a start command arrives; the overwrite event wins if both arrive in the same cycle. Host writes do not change bit 7.
- R6: Events set sticky status bits on the next cycle. The bit values are 0x01 receive OK, 0x02 transmit OK, 0x04 receive error, 0x08 transmit error, 0x10 ring overwrite, 0x20 counter overflow and 0x40 remote DMA complete.
- R7: Writing to the status register clears each of bits 6:0 that is written as 1. If an event arrives in the same cycle as the clear, its bit stays set.
- R8: `irq_o` is the OR over bits 6:0 of status AND mask. It follows the registered status and mask values.
- R9: A mask write stores bits 6:0. Mask bit 7 always reads 0.
- R10: A command write with bit 2 set raises the transmit request only if, after that write, the controller is running. The request clears on `tx_ok_ev` or `tx_err_ev`, and it clears when the controller becomes offline. A new request written in the same cycle as a completion event wins.
- R11: Status bit 0x20 is set when any bit of `tally_msb` goes from 0 to 1. A bit that stays high does not set it again after the host clears it.
- R12: After hardware reset the command readback is 0x01, the controller is offline, status reads 0x80, mask reads 0x00 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Write strobe for the command byte |
| sts_wr | input | 1 | Write strobe for status write-1-to-clear |
| msk_wr | input | 1 | Write strobe for the interrupt mask |
| wr_data | input | 8 | Host write data |
| rx_busy | input | 1 | A frame is being received |
| tx_busy | input | 1 | A frame is being transmitted |
| rx_ok_ev | input | 1 | Pulse: frame received without error |
| tx_ok_ev | input | 1 | Pulse: frame sent without error |
| rx_err_ev | input | 1 | Pulse: frame received with error |
| tx_err_ev | input | 1 | Pulse: transmission failed or aborted |
| ring_ovw_ev | input | 1 | Pulse: receive ring overwrite |
| ring_drain_ev | input | 1 | Pulse: a packet was removed from the ring |
| rdma_done_ev | input | 1 | Pulse: remote DMA finished |
| tally_msb | input | NUM_TALLY | MSB of each network tally counter |
| cmd_rdata | output | 8 | Command byte readback |
| sts_rdata | output | 8 | Interrupt status readback |
| msk_rdata | output | 8 | Interrupt mask readback |
| page_o | output | 2 | Selected register page |
| rdma_cmd_o | output | 3 | Remote DMA command field |
| online_o | output | 1 | Controller may start new frames |
| tx_req_o | output | 1 | Transmit request pending |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench holds a busy input high through a stop and checks that status bit 7 stays low until the last frame ends. A design that goes offline at once would raise bit 7 early and drop a transmit request that is still pending. Several collisions are checked:
- A clear and an event in the same cycle: a design that gets this wrong loses the event.
- A transmit request and a completion in the same cycle: a design that gets this wrong loses the new request.
- Stop and start written together: a design that gets this wrong restarts the controller.

The bench also checks that a tally MSB held high does not set the overflow bit again after a clear, that host writes to bit 7 have no effect, and that an overwrite keeps bit 7 high while the controller is running until a drain event arrives.

// File: rtl/cmdirq_pkg.sv
package cmdirq_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } run_state_e;

    localparam int BYTE_W      = 8;
    localparam int PAGE_W      = 2;
    localparam int RDMA_W      = 3;

    // command byte fields (decoded by the host driver, so positions are fixed)
    localparam int CMD_STOP    = 0;
    localparam int CMD_START   = 1;
    localparam int CMD_TXREQ   = 2;
    localparam int CMD_RDMA_LO = 3;
    localparam int CMD_PAGE_LO = CMD_RDMA_LO + RDMA_W;

    // sticky status event positions
    localparam int EV_RXOK     = 0;
    localparam int EV_TXOK     = 1;
    localparam int EV_RXERR    = 2;
    localparam int EV_TXERR    = 3;
    localparam int EV_OVW      = 4;
    localparam int EV_CNT      = 5;
    localparam int EV_RDMA     = 6;
    localparam int NUM_EV      = 7;
    localparam int STS_RST     = NUM_EV;

endpackage

// File: rtl/cmd_ctrl.sv
module cmd_ctrl
    import cmdirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wr_i,
    input  logic [BYTE_W-1:0]   wr_data_i,
    input  logic                busy_i,
    input  logic                tx_end_i,
    output logic [BYTE_W-1:0]   cmd_byte_o,
    output logic [PAGE_W-1:0]   page_o,
    output logic [RDMA_W-1:0]   rdma_o,
    output logic                online_o,
    output logic                offline_o,
    output logic                tx_req_o,
    output logic                start_cmd_o
);

    typedef struct packed {
        run_state_e         state;
        logic               stop_bit;
        logic               start_bit;
        logic               tx_req;
        logic [RDMA_W-1:0]  rdma;
        logic [PAGE_W-1:0]  page;
    } cmd_regs_t;

    cmd_regs_t cur_q, nxt_d;
    logic      stop_req;
    logic      start_req;

    assign stop_req  = cmd_wr_i & wr_data_i[CMD_STOP];
    assign start_req = cmd_wr_i & ~wr_data_i[CMD_STOP] & wr_data_i[CMD_START];

    always_comb begin
        nxt_d = cur_q;

        if (cmd_wr_i) begin
            nxt_d.stop_bit  = wr_data_i[CMD_STOP];
            nxt_d.start_bit = wr_data_i[CMD_START];
            nxt_d.rdma      = wr_data_i[CMD_RDMA_LO +: RDMA_W];
            nxt_d.page      = wr_data_i[CMD_PAGE_LO +: PAGE_W];
        end

        // run state: stop outranks start; draining waits for the frame in flight
        if (stop_req) begin
            if (cur_q.state != ST_OFF) begin
                nxt_d.state = busy_i ? ST_DRAIN : ST_OFF;
            end
        end else if (start_req) begin
            nxt_d.state = ST_RUN;
        end else if (cur_q.state == ST_DRAIN && !busy_i) begin
            nxt_d.state = ST_OFF;
        end

        // transmit request: completion clears, a fresh request while running sets
        if (tx_end_i) begin
            nxt_d.tx_req = 1'b0;
        end
        if (cmd_wr_i && wr_data_i[CMD_TXREQ] && nxt_d.state == ST_RUN) begin
            nxt_d.tx_req = 1'b1;
        end
        if (nxt_d.state == ST_OFF) begin
            nxt_d.tx_req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_OFF, stop_bit: 1'b1, start_bit: 1'b0,
                       tx_req: 1'b0, rdma: '0, page: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cmd_byte_o  = {cur_q.page, cur_q.rdma, cur_q.tx_req,
                          cur_q.start_bit, cur_q.stop_bit};
    assign page_o      = cur_q.page;
    assign rdma_o      = cur_q.rdma;
    assign online_o    = (cur_q.state == ST_RUN);
    assign offline_o   = (cur_q.state == ST_OFF);
    assign tx_req_o    = cur_q.tx_req;
    assign start_cmd_o = start_req;

    // R2
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_DRAIN && busy_i && !cmd_wr_i) |=> (cur_q.state == ST_DRAIN));

    // R3
    idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && wr_data_i[CMD_STOP] && !busy_i) |=> offline_o);

    // R4
    start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && !wr_data_i[CMD_STOP] && wr_data_i[CMD_START]) |=> online_o);

    // R10
    tx_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_end_i && !cmd_wr_i) |=> !tx_req_o);

endmodule

// File: rtl/irq_status.sv
module irq_status
    import cmdirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EV-1:0]   ev_i,
    input  logic                sts_wr_i,
    input  logic                msk_wr_i,
    input  logic [NUM_EV-1:0]   wr_bits_i,
    input  logic                offline_i,
    input  logic                start_cmd_i,
    input  logic                drain_i,
    output logic [BYTE_W-1:0]   sts_o,
    output logic [BYTE_W-1:0]   msk_o,
    output logic                irq_o
);

    typedef struct packed {
        logic [NUM_EV-1:0] sts;
        logic [NUM_EV-1:0] msk;
        logic              ovw_lock;
    } irq_regs_t;

    irq_regs_t         cur_q, nxt_d;
    logic [NUM_EV-1:0] clr_bits;
    logic [NUM_EV-1:0] live_bits;

    always_comb begin
        nxt_d    = cur_q;
        clr_bits = sts_wr_i ? wr_bits_i : '0;

        // set outranks clear so no event is lost
        nxt_d.sts = (cur_q.sts & ~clr_bits) | ev_i;

        if (msk_wr_i) begin
            nxt_d.msk = wr_bits_i;
        end

        if (ev_i[EV_OVW]) begin
            nxt_d.ovw_lock = 1'b1;
        end else if (drain_i || start_cmd_i) begin
            nxt_d.ovw_lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    for (genvar gi = 0; gi < NUM_EV; gi++) begin : g_gate
        assign live_bits[gi] = cur_q.sts[gi] & cur_q.msk[gi];
    end

    assign irq_o = |live_bits;
    assign sts_o = {offline_i | cur_q.ovw_lock, cur_q.sts};
    assign msk_o = {1'b0, cur_q.msk};

    // R6
    ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((cur_q.sts & $past(ev_i)) == $past(ev_i)));

    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_i && ev_i == '0) |=> ((cur_q.sts & $past(wr_bits_i)) == '0));

    // R5
    ovw_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i[EV_OVW] |=> sts_o[STS_RST]);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.msk == '0) |-> !irq_o);

endmodule

// File: rtl/tally_edge.sv
module tally_edge #(
    parameter int NUM_TALLY = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TALLY-1:0] tally_i,
    output logic                 rise_o
);

    logic [NUM_TALLY-1:0] prev_d, prev_q;
    logic [NUM_TALLY-1:0] edge_bits;

    always_comb begin
        prev_d = tally_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    for (genvar gi = 0; gi < NUM_TALLY; gi++) begin : g_edge
        assign edge_bits[gi] = tally_i[gi] & ~prev_q[gi];
    end

    assign rise_o = |edge_bits;

endmodule

// File: rtl/cmd_irq_ctrl.sv
module cmd_irq_ctrl
    import cmdirq_pkg::*;
#(
    parameter int NUM_TALLY = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic                 sts_wr,
    input  logic                 msk_wr,
    input  logic [7:0]           wr_data,
    input  logic                 rx_busy,
    input  logic                 tx_busy,
    input  logic                 rx_ok_ev,
    input  logic                 tx_ok_ev,
    input  logic                 rx_err_ev,
    input  logic                 tx_err_ev,
    input  logic                 ring_ovw_ev,
    input  logic                 ring_drain_ev,
    input  logic                 rdma_done_ev,
    input  logic [NUM_TALLY-1:0] tally_msb,
    output logic [7:0]           cmd_rdata,
    output logic [7:0]           sts_rdata,
    output logic [7:0]           msk_rdata,
    output logic [1:0]           page_o,
    output logic [2:0]           rdma_cmd_o,
    output logic                 online_o,
    output logic                 tx_req_o,
    output logic                 irq_o
);

    logic              busy;
    logic              tx_end;
    logic              offline;
    logic              start_cmd;
    logic              cnt_rise;
    logic [NUM_EV-1:0] ev_vec;

    assign busy   = rx_busy | tx_busy;
    assign tx_end = tx_ok_ev | tx_err_ev;

    cmd_ctrl u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr_i    (cmd_wr),
        .wr_data_i   (wr_data),
        .busy_i      (busy),
        .tx_end_i    (tx_end),
        .cmd_byte_o  (cmd_rdata),
        .page_o      (page_o),
        .rdma_o      (rdma_cmd_o),
        .online_o    (online_o),
        .offline_o   (offline),
        .tx_req_o    (tx_req_o),
        .start_cmd_o (start_cmd)
    );

    tally_edge #(.NUM_TALLY(NUM_TALLY)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .tally_i (tally_msb),
        .rise_o  (cnt_rise)
    );

    always_comb begin
        ev_vec           = '0;
        ev_vec[EV_RXOK]  = rx_ok_ev;
        ev_vec[EV_TXOK]  = tx_ok_ev;
        ev_vec[EV_RXERR] = rx_err_ev;
        ev_vec[EV_TXERR] = tx_err_ev;
        ev_vec[EV_OVW]   = ring_ovw_ev;
        ev_vec[EV_CNT]   = cnt_rise;
        ev_vec[EV_RDMA]  = rdma_done_ev;
    end

    irq_status u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (ev_vec),
        .sts_wr_i    (sts_wr),
        .msk_wr_i    (msk_wr),
        .wr_bits_i   (wr_data[NUM_EV-1:0]),
        .offline_i   (offline),
        .start_cmd_i (start_cmd),
        .drain_i     (ring_drain_ev),
        .sts_o       (sts_rdata),
        .msk_o       (msk_rdata),
        .irq_o       (irq_o)
    );

    // R12
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!online_o) |-> !tx_req_o || !offline);

endmodule

// File: tb/test_cmd_irq_ctrl.sv
module test_cmd_irq_ctrl;

    localparam int NT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 0, sts_wr = 0, msk_wr = 0;
    logic [7:0]    wr_data = 0;
    logic          rx_busy = 0, tx_busy = 0;
    logic          rx_ok_ev = 0, tx_ok_ev = 0, rx_err_ev = 0, tx_err_ev = 0;
    logic          ring_ovw_ev = 0, ring_drain_ev = 0, rdma_done_ev = 0;
    logic [NT-1:0] tally_msb = '0;
    logic [7:0]    cmd_rdata, sts_rdata, msk_rdata;
    logic [1:0]    page_o;
    logic [2:0]    rdma_cmd_o;
    logic          online_o, tx_req_o, irq_o;

    always #5 clk = ~clk;

    cmd_irq_ctrl #(.NUM_TALLY(NT)) i_cmd_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .sts_wr(sts_wr), .msk_wr(msk_wr),
        .wr_data(wr_data), .rx_busy(rx_busy), .tx_busy(tx_busy),
        .rx_ok_ev(rx_ok_ev), .tx_ok_ev(tx_ok_ev), .rx_err_ev(rx_err_ev),
        .tx_err_ev(tx_err_ev), .ring_ovw_ev(ring_ovw_ev), .ring_drain_ev(ring_drain_ev),
        .rdma_done_ev(rdma_done_ev), .tally_msb(tally_msb),
        .cmd_rdata(cmd_rdata), .sts_rdata(sts_rdata), .msk_rdata(msk_rdata),
        .page_o(page_o), .rdma_cmd_o(rdma_cmd_o), .online_o(online_o),
        .tx_req_o(tx_req_o), .irq_o(irq_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit checking = 0;

    // behavioural reference: 0 offline, 1 running, 2 draining
    int       m_state;
    bit       m_stop, m_start, m_txp, m_ovw;
    bit [2:0] m_rdma;
    bit [1:0] m_page;
    bit [6:0] m_sts, m_msk;
    bit [NT-1:0] m_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_stop = 1; m_start = 0; m_txp = 0; m_ovw = 0;
            m_rdma = 0; m_page = 0; m_sts = 0; m_msk = 0; m_prev = 0;
        end else begin
            bit busy, stopw, startw, cnt;
            int ns;
            bit [6:0] ev, clr;
            busy   = rx_busy || tx_busy;
            stopw  = cmd_wr && wr_data[0];
            startw = cmd_wr && !wr_data[0] && wr_data[1];
            ns = m_state;
            if (stopw) begin
                if (m_state != 0) ns = busy ? 2 : 0;
            end else if (startw) ns = 1;
            else if (m_state == 2 && !busy) ns = 0;
            if (tx_ok_ev || tx_err_ev) m_txp = 0;
            if (cmd_wr && wr_data[2] && ns == 1) m_txp = 1;
            if (ns == 0) m_txp = 0;
            cnt = ((tally_msb & ~m_prev) != 0);
            m_prev = tally_msb;
            ev = {rdma_done_ev, cnt, ring_ovw_ev, tx_err_ev, rx_err_ev, tx_ok_ev, rx_ok_ev};
            clr = sts_wr ? wr_data[6:0] : 7'd0;
            m_sts = (m_sts & ~clr) | ev;
            if (ring_ovw_ev) m_ovw = 1;
            else if (ring_drain_ev || startw) m_ovw = 0;
            if (msk_wr) m_msk = wr_data[6:0];
            if (cmd_wr) begin
                m_stop = wr_data[0]; m_start = wr_data[1];
                m_rdma = wr_data[5:3]; m_page = wr_data[7:6];
            end
            m_state = ns;
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            chk(cmd_rdata, {m_page, m_rdma, m_txp, m_start, m_stop}, "R1 cmd readback");
            chk({6'd0, page_o}, {6'd0, m_page}, "R1 page");
            chk({5'd0, rdma_cmd_o}, {5'd0, m_rdma}, "R1 rdma");
            chk({7'd0, online_o}, {7'd0, m_state == 1}, "R2 online");
            chk({7'd0, sts_rdata[7]}, {7'd0, (m_state == 0) || m_ovw}, "R5 status bit7");
            chk({1'b0, sts_rdata[6:0]}, {1'b0, m_sts}, "R6 status");
            chk(msk_rdata, {1'b0, m_msk}, "R9 mask");
            chk({7'd0, irq_o}, {7'd0, (m_sts & m_msk) != 0}, "R8 irq");
            chk({7'd0, tx_req_o}, {7'd0, m_txp}, "R10 tx request");
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cmd_wr = 0; sts_wr = 0; msk_wr = 0;
        rx_ok_ev = 0; tx_ok_ev = 0; rx_err_ev = 0; tx_err_ev = 0;
        ring_ovw_ev = 0; ring_drain_ev = 0; rdma_done_ev = 0;
    endtask

    task automatic do_cmd(input logic [7:0] b);
        cmd_wr = 1; wr_data = b; tick(); idle();
    endtask

    task automatic do_sts(input logic [7:0] b);
        sts_wr = 1; wr_data = b; tick(); idle();
    endtask

    task automatic do_msk(input logic [7:0] b);
        msk_wr = 1; wr_data = b; tick(); idle();
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL R12 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        checking = 1;
        // R12 reset state
        chk(cmd_rdata, 8'h01, "R12 cmd after reset");
        chk(sts_rdata, 8'h80, "R12 status after reset");
        chk(msk_rdata, 8'h00, "R12 mask after reset");
        chk({6'd0, irq_o, online_o}, 8'h00, "R12 irq/online after reset");

        // R4 start
        do_cmd(8'h02);
        chk({7'd0, online_o}, 8'h01, "R4 online after start");
        chk(sts_rdata, 8'h00, "R4 bit7 cleared by start");
        // R1 page and DMA fields
        do_cmd(8'hC2);
        chk({6'd0, page_o}, 8'h03, "R1 page 3");
        do_cmd(8'h62);
        chk({5'd0, rdma_cmd_o}, 8'h04, "R1 rdma field");
        chk(cmd_rdata, 8'h62, "R1 readback");
        do_cmd(8'h02);

        // R9 mask
        do_msk(8'hFF);
        chk(msk_rdata, 8'h7F, "R9 mask bit7 reads 0");
        // R6 / R8
        rx_ok_ev = 1; tick(); idle();
        chk(sts_rdata, 8'h01, "R6 receive OK bit");
        chk({7'd0, irq_o}, 8'h01, "R8 irq on");
        do_msk(8'h7E);
        chk({7'd0, irq_o}, 8'h00, "R8 irq masked");
        do_msk(8'h7F);
        // R7 clears
        do_sts(8'h01);
        chk(sts_rdata, 8'h00, "R7 w1c");
        sts_wr = 1; wr_data = 8'h04; rx_err_ev = 1; tick(); idle();
        chk(sts_rdata, 8'h04, "R7 event beats clear");
        do_sts(8'hFF);
        chk(sts_rdata, 8'h00, "R7 clear all");

        // R10 transmit request
        do_cmd(8'h06);
        chk({7'd0, tx_req_o}, 8'h01, "R10 request set");
        tx_ok_ev = 1; tick(); idle();
        chk({7'd0, tx_req_o}, 8'h00, "R10 cleared by done");
        chk(sts_rdata, 8'h02, "R6 transmit OK bit");
        cmd_wr = 1; wr_data = 8'h06; tx_err_ev = 1; tick(); idle();
        chk({7'd0, tx_req_o}, 8'h01, "R10 new request wins");
        tx_err_ev = 1; tick(); idle();
        chk({7'd0, tx_req_o}, 8'h00, "R10 cleared by error");
        do_sts(8'hFF);

        // R11 tally rise
        tally_msb = 3'b010; tick();
        chk(sts_rdata, 8'h20, "R11 counter overflow bit");
        do_sts(8'h20);
        tick(); tick();
        chk(sts_rdata, 8'h00, "R11 held MSB no re-set");
        tally_msb = '0; tick();

        // R2 draining stop
        do_cmd(8'h06);
        tx_busy = 1;
        do_cmd(8'h01);
        chk({7'd0, online_o}, 8'h00, "R2 online drops at stop");
        chk({7'd0, sts_rdata[7]}, 8'h00, "R2 not offline while busy");
        tick(); tick(); tick();
        chk({7'd0, sts_rdata[7]}, 8'h00, "R2 still draining");
        chk({7'd0, tx_req_o}, 8'h01, "R10 request kept while draining");
        tx_busy = 0; tick();
        chk({7'd0, sts_rdata[7]}, 8'h01, "R2 offline after frame");
        chk({7'd0, tx_req_o}, 8'h00, "R10 cleared on offline");
        do_cmd(8'h04);
        chk({7'd0, tx_req_o}, 8'h00, "R10 no request while offline");

        // R3 stop wins over start
        do_cmd(8'h02);
        do_cmd(8'h03);
        chk({7'd0, online_o}, 8'h00, "R3 stop wins");
        chk({7'd0, sts_rdata[7]}, 8'h01, "R3 offline next cycle");

        // R5 overwrite holds bit7
        do_cmd(8'h02);
        ring_ovw_ev = 1; tick(); idle();
        chk(sts_rdata, 8'h90, "R5 overwrite sets bit7");
        do_sts(8'h80);
        chk(sts_rdata, 8'h90, "R5 bit7 write ignored");
        ring_drain_ev = 1; tick(); idle();
        chk(sts_rdata, 8'h10, "R5 drain clears bit7");
        do_sts(8'h10);

        // mixed traffic against the reference model
        for (int i = 0; i < 4000; i++) begin
            cmd_wr        = ($urandom_range(0, 15) == 0);
            sts_wr        = ($urandom_range(0, 9) == 0);
            msk_wr        = ($urandom_range(0, 19) == 0);
            wr_data       = 8'($urandom);
            rx_ok_ev      = ($urandom_range(0, 7) == 0);
            tx_ok_ev      = ($urandom_range(0, 7) == 0);
            rx_err_ev     = ($urandom_range(0, 11) == 0);
            tx_err_ev     = ($urandom_range(0, 11) == 0);
            ring_ovw_ev   = ($urandom_range(0, 15) == 0);
            ring_drain_ev = ($urandom_range(0, 9) == 0);
            rdma_done_ev  = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 19) == 0) rx_busy = ~rx_busy;
            if ($urandom_range(0, 19) == 0) tx_busy = ~tx_busy;
            if ($urandom_range(0, 29) == 0) tally_msb = NT'($urandom);
            tick();
        end
        idle();
        tick();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule